// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block produces one high-true, edge-aligned pulse-width-modulated output from a 16-bit up-counter. A selectable prescaler sets the rate at which the counter advances. A period register (the terminal count) fixes how far the counter runs before it wraps to zero, and a threshold register fixes how long the output stays high at the start of each cycle. A host programs the block through a one-cycle write strobe with a two-bit register select, and reads any register back through a combinational read port.

The threshold register is double-buffered, with one quirk: it accepts only a single write per PWM cycle, and any further write in the same cycle is silently discarded. A cycle ends either by the counter wrapping or by a write to the count register, which clears the count and the prescaler at once. Each cycle end copies the buffered period and threshold into the active copies and re-arms the threshold buffer. Software that writes the threshold more often than once a cycle can therefore force a write through by restarting the count first, at the cost of a shortened cycle.

Top module: `pwm_edge_timer`

## Requirements
- R1: After reset, reading select 0 returns 0, select 1 returns 0xFFFF, select 2 returns 0, select 3 returns 0, and the output is low.
- R2: Register selects are 0 control (bit 0 run enable, bits 2:1 prescale choice), 1 period, 2 threshold and 3 count; reads of selects 0 to 2 return the last value accepted.
- R3: With period value P and divide ratio D, the count read N clocks after a count write is floor(N/D) mod (P+1), so one cycle lasts (P+1)*D clocks.
- R4: Within each cycle the output is high for min(T, P+1)*D clocks and low for the rest; T = 0 keeps it low and T > P keeps it high.
- R5: Only the first threshold write in a cycle is taken; a later write in the same cycle leaves both the threshold readback and the output unchanged.
- R6: A counter wrap or a count write re-arms the threshold buffer, so the next threshold write is taken.
- R7: A taken threshold write and any period write reach the output and the counter only at the next cycle end, never within the running cycle.
- R8: A write of any value to select 3 clears the count and the prescaler on the next clock, ending the current cycle.
- R9: With the run bit clear the count holds its value and the output stays low.
- R10: Prescale choice k divides the clock by 4 to the power k, giving ratios 1, 4, 16 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register select for the readback |
| rd_data | output | 16 | Readback data, combinational from rd_addr |
| pwm_out | output | 1 | High-true PWM output |

## Verification
The hardest state to reach is a second threshold write landing in a cycle that has already accepted one, while the difference stays visible at the ports. The bench uses a long period at divide-by-1 so that two back-to-back writes fall inside one cycle, then reads the buffered value and measures the duty of the following cycle. Deferred loading is shown by sampling the output and the count inside the running cycle after a buffered write, where an immediate load would give a different value, and re-arming is driven both by a count write and by waiting past a wrap of a short period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_DIV_LSB = 1;

endpackage

// File: rtl/pwm_reset_sync.sv
module pwm_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W = 2,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             restart,
  output logic             tick
);

  localparam int DIV_W = ((1 << SEL_W) - 1) * STEP;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] pre_d;
  logic [DIV_W-1:0] limit;
  int unsigned      span;

  always_comb begin
    span  = (32'd1 << (int'(div_sel) * STEP)) - 32'd1;
    limit = DIV_W'(span);
  end

  // Terminal test uses >= so a smaller ratio chosen mid-count recovers at once.
  assign tick = run && (pre_q >= limit);

  always_comb begin
    if (!run || restart || tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period_buf,
  output logic [CNT_W-1:0] period_act,
  output logic             boundary
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pbuf_q, pbuf_d;
  logic [CNT_W-1:0] pact_q, pact_d;
  logic             at_top;
  logic             wrap;

  assign at_top   = (cnt_q == pact_q);
  assign wrap     = tick && at_top && !clear;
  assign boundary = wrap || clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_top ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    pbuf_d = period_wr ? period_wdata : pbuf_q;
    pact_d = boundary  ? pbuf_q       : pact_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pbuf_q <= '1;
      pact_q <= '1;
    end else begin
      cnt_q  <= cnt_d;
      pbuf_q <= pbuf_d;
      pact_q <= pact_d;
    end
  end

  assign count      = cnt_q;
  assign period_buf = pbuf_q;
  assign period_act = pact_q;

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] thr_buf,
  output logic [CNT_W-1:0] thr_act,
  output logic             taken,
  output logic             pwm
);

  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             taken_q, taken_d;
  logic             pwm_q, pwm_d;
  logic             accept;

  // A write in the same cycle as a cycle end belongs to the new cycle.
  assign accept = thr_wr && (boundary || !taken_q);

  always_comb begin
    buf_d   = accept ? thr_wdata : buf_q;
    act_d   = boundary ? buf_q : act_q;
    taken_d = boundary ? thr_wr : (taken_q || thr_wr);
    pwm_d   = run && (count < act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      act_q   <= '0;
      taken_q <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      act_q   <= act_d;
      taken_q <= taken_d;
      pwm_q   <= pwm_d;
    end
  end

  assign thr_buf = buf_q;
  assign thr_act = act_q;
  assign taken   = taken_q;
  assign pwm     = pwm_q;

endmodule

// File: rtl/pwm_edge_timer.sv
module pwm_edge_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 2,
  parameter int DIV_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out
);

  localparam int CTRL_W = SEL_W + 1;

  logic             rst_s_n;
  reg_sel_e         wsel;
  reg_sel_e         rsel;
  logic             ctrl_wr, period_wr, thr_wr, cnt_wr;
  logic             run_q, run_d;
  logic [SEL_W-1:0] div_q, div_d;
  logic             tick;
  logic             boundary;
  logic             taken;
  logic [CNT_W-1:0] count, period_buf, period_act, thr_buf, thr_act;
  logic [CTRL_W-1:0] ctrl_view;

  pwm_reset_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  assign wsel      = reg_sel_e'(wr_addr);
  assign rsel      = reg_sel_e'(rd_addr);
  assign ctrl_wr   = wr_en && (wsel == SEL_CTRL);
  assign period_wr = wr_en && (wsel == SEL_PERIOD);
  assign thr_wr    = wr_en && (wsel == SEL_THRESH);
  assign cnt_wr    = wr_en && (wsel == SEL_COUNT);

  always_comb begin
    run_d = run_q;
    div_d = div_q;
    if (ctrl_wr) begin
      run_d = wr_data[CTRL_RUN_BIT];
      div_d = wr_data[CTRL_DIV_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q <= 1'b0;
      div_q <= '0;
    end else begin
      run_q <= run_d;
      div_q <= div_d;
    end
  end

  pwm_prescaler #(
    .SEL_W (SEL_W),
    .STEP  (DIV_STEP)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run     (run_q),
    .div_sel (div_q),
    .restart (cnt_wr),
    .tick    (tick)
  );

  pwm_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .tick         (tick),
    .clear        (cnt_wr),
    .period_wr    (period_wr),
    .period_wdata (wr_data),
    .count        (count),
    .period_buf   (period_buf),
    .period_act   (period_act),
    .boundary     (boundary)
  );

  pwm_compare #(
    .CNT_W (CNT_W)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .boundary  (boundary),
    .thr_wr    (thr_wr),
    .thr_wdata (wr_data),
    .run       (run_q),
    .count     (count),
    .thr_buf   (thr_buf),
    .thr_act   (thr_act),
    .taken     (taken),
    .pwm       (pwm_out)
  );

  assign ctrl_view = {div_q, run_q};

  always_comb begin
    case (rsel)
      SEL_CTRL:   rd_data = CNT_W'(ctrl_view);
      SEL_PERIOD: rd_data = period_buf;
      SEL_THRESH: rd_data = thr_buf;
      SEL_COUNT:  rd_data = count;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pwm_edge_timer_chk.sv
module pwm_edge_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic             thr_wr,
  input logic             run,
  input logic             boundary,
  input logic             taken,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period_act,
  input logic [CNT_W-1:0] thr_buf,
  input logic [CNT_W-1:0] thr_act,
  input logic             pwm_out
);

  AST_COUNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    count <= period_act); // R3

  AST_ZERO_THRESH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_act == '0) |=> !pwm_out); // R4

  AST_LATE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && taken && !boundary) |=> $stable(thr_buf)); // R5

  AST_CYCLE_END_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !thr_wr) |=> !taken); // R6

  AST_THRESH_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(thr_act)); // R7

  AST_PERIOD_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(period_act)); // R7

  AST_COUNT_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == '0)); // R8

  AST_STOPPED_OUTPUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_out); // R9

  AST_STOPPED_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count)); // R9

endmodule

bind pwm_edge_timer pwm_edge_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .cnt_wr     (cnt_wr),
  .thr_wr     (thr_wr),
  .run        (run_q),
  .boundary   (boundary),
  .taken      (taken),
  .count      (count),
  .period_act (period_act),
  .thr_buf    (thr_buf),
  .thr_act    (thr_act),
  .pwm_out    (pwm_out)
);

// File: tb/pwm_edge_timer_tb.sv
module pwm_edge_timer_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        pwm_out;

  int n_chk;
  int n_fail;

  pwm_edge_timer u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, after the write edge.
  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 2'(a);
    wr_data = 16'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 2'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic window(input int len, output int highs);
    highs = 0;
    repeat (len) begin
      @(negedge clk);
      highs += int'(pwm_out);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    int v2;
    int h;
    n_chk   = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1: reset state
    check("R1 pwm low", int'(pwm_out), 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 period", v, 16'hFFFF);
    rd(2, v); check("R1 thresh", v, 0);
    rd(3, v); check("R1 count", v, 0);

    // Sweep: ratios 1, 4, 16 over small periods and every threshold to P+2.
    for (int s = 0; s < 3; s++) begin
      int dv;
      dv = 1 << (2 * s);
      step(1);
      wr(0, (s << 1) | 1);
      rd(0, v); check("R2 ctrl readback", v, (s << 1) | 1);
      for (int mi = 0; mi < 4; mi++) begin
        int md;
        md = (mi == 3) ? 5 : mi;
        for (int c = 0; c <= md + 2; c++) begin
          int m;
          int expd;
          step(1);
          wr(3, 0);
          wr(2, c);
          wr(1, md);
          wr(3, 0);
          rd(3, v); check("R8 count cleared", v, 0);
          rd(1, v); check("R2 period readback", v, md);
          m = 2 * dv + 3;
          step(m);
          rd(3, v); check("R3 R10 count position", v, (m / dv) % (md + 1));
          step(2);
          window((md + 1) * dv, h);
          expd = ((c < md + 1) ? c : md + 1) * dv;
          check("R4 duty per cycle", h, expd);
        end
      end
    end

    // R10: ratio 64
    step(1);
    wr(0, 7);
    wr(3, 0);
    wr(2, 1);
    wr(1, 1);
    wr(3, 0);
    step(200);
    rd(3, v); check("R10 divide-by-64 count", v, (200 / 64) % 2);
    window(128, h); check("R10 divide-by-64 duty", h, 64);

    // R5: second write in one long cycle is lost
    step(1);
    wr(0, 1);
    wr(1, 200);
    wr(3, 0);
    wr(2, 30);
    wr(2, 90);
    rd(2, v); check("R5 late write dropped", v, 30);
    step(1);
    wr(3, 0);
    step(2);
    window(201, h); check("R5 duty from first write", h, 30);

    // R6: count write re-arms
    step(1);
    wr(3, 0);
    wr(2, 90);
    rd(2, v); check("R6 re-armed by count write", v, 90);

    // R7: period write deferred to cycle end
    step(1);
    wr(3, 0);
    wr(1, 3);
    step(49);
    rd(3, v); check("R7 old period still running", v, 50);

    // R6: wrap re-arms (period 3 now loaded)
    step(1);
    wr(3, 0);
    wr(2, 1);
    step(10);
    wr(2, 2);
    rd(2, v); check("R6 re-armed by wrap", v, 2);

    // R7: threshold deferred to cycle end at ratio 64, period 9
    step(1);
    wr(0, 7);
    wr(3, 0);
    wr(2, 5);
    wr(1, 9);
    wr(3, 0);
    wr(2, 2);
    step(248);
    check("R7 active threshold unchanged mid-cycle", int'(pwm_out), 1);
    step(451);
    window(640, h); check("R7 new threshold after cycle end", h, 128);
    rd(2, v); check("R7 threshold readback", v, 2);

    // R9: stopped
    step(1);
    wr(0, 1);
    wr(1, 3);
    wr(3, 0);
    wr(2, 90);
    wr(3, 0);
    step(5);
    check("R9 running full duty", int'(pwm_out), 1);
    wr(0, 0);
    step(3);
    rd(3, v);
    step(20);
    rd(3, v2);
    check("R9 count holds", v2, v);
    window(20, h); check("R9 output low", h, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule